// File: doc/BRIEF.md
# Vectored Nested Interrupt Controller

This block collects thirty-two level-sensitive request lines, plus a software request word that the host can set and clear, and turns them into two processor interrupt lines. The fast line takes every source that the host has steered to it. The normal line takes the enabled sources that are not steered to the fast line. The normal line is also gated by a priority mask that depends on which interrupt is in service at the moment.

Sixteen programmable slots each bind one source number to a priority level and a handler address. Slot 0 has the highest priority. Any source that no slot claims falls to a seventeenth, unvectored level that uses a default handler address. When the handler reads the vector register, the block acknowledges the most urgent pending level and saves the level it displaced. Sources at that level and below are then masked until the handler writes the vector register. The write returns to the saved level, so interrupts can nest to any depth.

Access is through a simple word-wide register port. A request is presented for one cycle. Read data and the error flag are valid combinationally in that same cycle, and any state change takes effect at the following clock edge.

Top module: `vic_nest`

## Requirements
- R1: After reset the current level is 17 (none in service). Every handler address, every slot control byte, the default address, the enable word, the steering word, the software word and the protection bit read back as zero, and both interrupt outputs are low.
- R2: Raw status (offset 0x08) is the request inputs OR the software word. Normal status (0x00) is raw AND enable AND NOT steering. Fast status (0x04) is raw AND steering, and does not depend on the enable word.
- R3: Writing a one to bit n at 0x10 sets enable bit n, and a one at 0x14 clears it. Offsets 0x18 and 0x1C do the same for the software word. Zero bits in the written data leave state unchanged. Reads of 0x10 and 0x18 return the enable word and the software word. The steering word at 0x0C and the protection bit (bit 0 of 0x20) are plain read/write registers.
- R4: A slot control byte at 0x200+4k enables slot k with bit 5 and names its source in bits 4:0. The mask for level L is the OR of one-hot source bits over the enabled slots below L. Level 16 uses all slots and level 17 uses all ones. irq_out is high exactly when normal status AND the mask of the current level is nonzero.
- R5: fiq_out is high exactly when fast status is nonzero, whatever the current level.
- R6: A read of 0x30 finds the lowest level i below the current level for which raw status AND mask[i+1] is nonzero. It saves the current level for i, makes i the current level, and returns handler address i. Handler addresses are at 0x100+4k, and level 16 uses the default address at 0x34.
- R7: A write to 0x30 ignores its data. If the current level is below 17, the write restores the level saved when that level was acknowledged, so nested acknowledgements unwind in reverse order.
- R8: A read of 0x30 with no qualifying level leaves all state unchanged. It returns the handler address of the current level, or the default address when no level is in service.
- R9: A write to 0x30 while the current level is 17 has no effect.
- R10: Reads of 0xFE0 to 0xFFC return the identification bytes 0x90, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1, one per word, in ascending address order.
- R11: A write to 0x00 is ignored without error. Any access to an unmapped or misaligned offset, any write to a read-only offset, and any read of a clear-only offset raises rsp_err for that cycle. Such an access returns zero and changes nothing.
- R12: A write to a slot control byte or a handler address affects irq_out gating and vector reads from the next clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Level-sensitive hardware request lines |
| req_valid | input | 1 | Register access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, same cycle |
| rsp_err | output | 1 | Access to an unmapped or misdirected offset |
| irq_out | output | 1 | Normal interrupt line |
| fiq_out | output | 1 | Fast interrupt line |

## Verification
The checker assumes that at most one access arrives per cycle, so an acknowledge and a service-end can never land on the same edge. It also assumes that the current level moves only through accesses to offset 0x30. The stimulus keeps req_valid low throughout reset and issues accesses one at a time. It changes request lines only between cycles, and it nests acknowledgements by raising sources of rising urgency while earlier ones are still in service. A behavioural model in the bench follows the same access stream and predicts both interrupt lines and every read value.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int NSRC    = 32;
    localparam int NSLOT   = 16;
    localparam int DW      = 32;
    localparam int AW      = 12;
    localparam int NLVL    = NSLOT + 1;          // idle level value
    localparam int LW      = $clog2(NLVL + 1);
    localparam int SRCW    = $clog2(NSRC);
    localparam int SLOT_EN = 5;

    typedef logic [NSRC-1:0] src_t;
    typedef logic [LW-1:0]   lvl_t;
    typedef logic [7:0]      ctl_t;

    typedef enum logic [3:0] {
        RK_IRQST, RK_FIQST, RK_RAW, RK_FSEL, RK_ENSET, RK_ENCLR,
        RK_SWSET, RK_SWCLR, RK_PROT, RK_VEC, RK_DEFV, RK_VADDR,
        RK_SLOT, RK_ID, RK_NONE
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [3:0] idx;
    } dec_t;

    function automatic dec_t vic_decode(input logic [AW-1:0] a);
        dec_t d;
        d.idx  = a[5:2];
        d.kind = RK_NONE;
        if (a[1:0] == 2'b00) begin
            if (a >= 12'h100 && a < 12'h140)      d.kind = RK_VADDR;
            else if (a >= 12'h200 && a < 12'h240) d.kind = RK_SLOT;
            else if (a >= 12'hFE0)                d.kind = RK_ID;
            else begin
                case (a)
                    12'h000: d.kind = RK_IRQST;
                    12'h004: d.kind = RK_FIQST;
                    12'h008: d.kind = RK_RAW;
                    12'h00C: d.kind = RK_FSEL;
                    12'h010: d.kind = RK_ENSET;
                    12'h014: d.kind = RK_ENCLR;
                    12'h018: d.kind = RK_SWSET;
                    12'h01C: d.kind = RK_SWCLR;
                    12'h020: d.kind = RK_PROT;
                    12'h030: d.kind = RK_VEC;
                    12'h034: d.kind = RK_DEFV;
                    default: d.kind = RK_NONE;
                endcase
            end
        end
        return d;
    endfunction

    function automatic logic [7:0] vic_id_byte(input logic [2:0] i);
        case (i)
            3'd0: return 8'h90;
            3'd1: return 8'h11;
            3'd2: return 8'h04;
            3'd3: return 8'h00;
            3'd4: return 8'h0D;
            3'd5: return 8'hF0;
            3'd6: return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction
endpackage

// File: rtl/vic_prio_mask.sv
module vic_prio_mask
    import vic_pkg::*;
(
    input  ctl_t [NSLOT-1:0] slot_ctl,
    output src_t [NLVL:0]    lvl_mask
);
    src_t slot_bit [NSLOT];

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        always_comb begin
            slot_bit[k] = '0;
            if (slot_ctl[k][SLOT_EN])
                slot_bit[k][slot_ctl[k][SRCW-1:0]] = 1'b1;
        end
    end

    always_comb begin
        src_t acc;
        acc = '0;
        for (int l = 0; l < NSLOT; l++) begin
            lvl_mask[l] = acc;
            acc = acc | slot_bit[l];
        end
        lvl_mask[NSLOT] = acc;
        lvl_mask[NLVL]  = '1;
    end
endmodule

// File: rtl/vic_level_stack.sv
module vic_level_stack
    import vic_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ack,
    input  logic               pop,
    input  src_t               raw,
    input  src_t [NLVL:0]      lvl_mask,
    output lvl_t               cur_lvl,
    output lvl_t               vec_sel
);
    localparam lvl_t IDLE = lvl_t'(NLVL);

    lvl_t cur_q;
    lvl_t prev_q [NLVL];
    logic found;
    lvl_t hit;

    always_comb begin
        found = 1'b0;
        hit   = '0;
        for (int i = 0; i < NLVL; i++) begin
            if (!found && lvl_t'(i) < cur_q && |(raw & lvl_mask[i+1])) begin
                found = 1'b1;
                hit   = lvl_t'(i);
            end
        end
        if (found)                     vec_sel = hit;
        else if (cur_q > lvl_t'(NSLOT)) vec_sel = lvl_t'(NSLOT);
        else                           vec_sel = cur_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= IDLE;
            for (int i = 0; i < NLVL; i++) prev_q[i] <= IDLE;
        end else if (ack && found) begin
            prev_q[hit] <= cur_q;
            cur_q       <= hit;
        end else if (pop && cur_q != IDLE) begin
            cur_q <= prev_q[cur_q];
        end
    end

    assign cur_lvl = cur_q;
endmodule

// File: rtl/vic_nest.sv
module vic_nest
    import vic_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [31:0]   irq_in,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [11:0]   req_addr,
    input  logic [31:0]   req_wdata,
    output logic [31:0]   rsp_rdata,
    output logic          rsp_err,
    output logic          irq_out,
    output logic          fiq_out
);
    dec_t          dec;
    logic          wr_en, rd_en;
    src_t          en_q, fsel_q, soft_q;
    logic          prot_q;
    logic [DW-1:0] vaddr_q [NLVL];
    ctl_t [NSLOT-1:0] ctl_q;
    src_t          raw, irq_st, fiq_st;
    src_t [NLVL:0] lvl_mask;
    lvl_t          cur_lvl, vec_sel;

    assign dec    = vic_decode(req_addr);
    assign wr_en  = req_valid &&  req_write;
    assign rd_en  = req_valid && !req_write;
    assign raw    = irq_in | soft_q;
    assign irq_st = raw & en_q & ~fsel_q;
    assign fiq_st = raw & fsel_q;

    vic_prio_mask u_mask (
        .slot_ctl (ctl_q),
        .lvl_mask (lvl_mask)
    );

    vic_level_stack u_lvl (
        .clk      (clk),
        .rst      (rst),
        .ack      (rd_en && dec.kind == RK_VEC),
        .pop      (wr_en && dec.kind == RK_VEC),
        .raw      (raw),
        .lvl_mask (lvl_mask),
        .cur_lvl  (cur_lvl),
        .vec_sel  (vec_sel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            fsel_q <= '0;
            soft_q <= '0;
            prot_q <= 1'b0;
            ctl_q  <= '0;
            for (int i = 0; i < NLVL; i++) vaddr_q[i] <= '0;
        end else if (wr_en) begin
            case (dec.kind)
                RK_FSEL:  fsel_q <= req_wdata[NSRC-1:0];
                RK_ENSET: en_q   <= en_q | req_wdata[NSRC-1:0];
                RK_ENCLR: en_q   <= en_q & ~req_wdata[NSRC-1:0];
                RK_SWSET: soft_q <= soft_q | req_wdata[NSRC-1:0];
                RK_SWCLR: soft_q <= soft_q & ~req_wdata[NSRC-1:0];
                RK_PROT:  prot_q <= req_wdata[0];
                RK_DEFV:  vaddr_q[NSLOT] <= req_wdata;
                RK_VADDR: vaddr_q[dec.idx] <= req_wdata;
                RK_SLOT:  ctl_q[dec.idx] <= req_wdata[7:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rsp_rdata = '0;
        if (rd_en) begin
            case (dec.kind)
                RK_IRQST: rsp_rdata = DW'(irq_st);
                RK_FIQST: rsp_rdata = DW'(fiq_st);
                RK_RAW:   rsp_rdata = DW'(raw);
                RK_FSEL:  rsp_rdata = DW'(fsel_q);
                RK_ENSET: rsp_rdata = DW'(en_q);
                RK_SWSET: rsp_rdata = DW'(soft_q);
                RK_PROT:  rsp_rdata = DW'(prot_q);
                RK_VEC:   rsp_rdata = vaddr_q[vec_sel];
                RK_DEFV:  rsp_rdata = vaddr_q[NSLOT];
                RK_VADDR: rsp_rdata = vaddr_q[dec.idx];
                RK_SLOT:  rsp_rdata = DW'(ctl_q[dec.idx]);
                RK_ID:    rsp_rdata = DW'(vic_id_byte(dec.idx[2:0]));
                default:  rsp_rdata = '0;
            endcase
        end
    end

    always_comb begin
        rsp_err = 1'b0;
        if (req_valid) begin
            if (dec.kind == RK_NONE)
                rsp_err = 1'b1;
            else if (req_write)
                rsp_err = dec.kind inside {RK_FIQST, RK_RAW, RK_ID};
            else
                rsp_err = dec.kind inside {RK_ENCLR, RK_SWCLR};
        end
    end

    assign irq_out = |(irq_st & lvl_mask[cur_lvl]);
    assign fiq_out = |fiq_st;
endmodule

// File: rtl/vic_nest_chk.sv
module vic_nest_chk
    import vic_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_write,
    input logic [11:0] req_addr,
    input logic        irq_out,
    input logic        fiq_out,
    input logic        rsp_err,
    input lvl_t        cur_lvl,
    input src_t        en_q,
    input src_t        fsel_q
);
    p_lvl_range_r1: assert property (@(posedge clk) disable iff (rst)
        cur_lvl <= lvl_t'(NLVL));

    p_no_en_no_irq_r2: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0) |-> !irq_out);

    p_no_sel_no_fiq_r5: assert property (@(posedge clk) disable iff (rst)
        (fsel_q == '0) |-> !fiq_out);

    p_drop_on_ack_r6: assert property (@(posedge clk) disable iff (rst)
        (cur_lvl < $past(cur_lvl)) |->
            $past(req_valid && !req_write && req_addr == 12'h030));

    p_rise_on_pop_r7: assert property (@(posedge clk) disable iff (rst)
        (cur_lvl > $past(cur_lvl)) |->
            $past(req_valid && req_write && req_addr == 12'h030));

    p_err_needs_access_r11: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> req_valid);
endmodule

bind vic_nest vic_nest_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .irq_out   (irq_out),
    .fiq_out   (fiq_out),
    .rsp_err   (rsp_err),
    .cur_lvl   (cur_lvl),
    .en_q      (en_q),
    .fsel_q    (fsel_q)
);

// File: tb/vic_nest_tb.sv
`timescale 1ns/1ps
module vic_nest_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] irq_in = '0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        rsp_err, irq_out, fiq_out;

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    // reference state
    logic [31:0] m_hw, m_soft, m_en, m_fsel;
    logic        m_prot;
    logic [31:0] m_vaddr [17];
    logic [7:0]  m_ctl [16];
    int          m_cur;
    int          m_prev [17];

    always #2 clk = ~clk;

    vic_nest u_dut (
        .clk(clk), .rst(rst), .irq_in(irq_in),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .irq_out(irq_out), .fiq_out(fiq_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_mask(input int l);
        logic [31:0] m = '0;
        if (l >= 17) return '1;
        for (int j = 0; j < l && j < 16; j++)
            if (m_ctl[j][5]) m[m_ctl[j][4:0]] = 1'b1;
        return m;
    endfunction

    function automatic logic [31:0] m_raw();
        return m_hw | m_soft;
    endfunction

    function automatic int m_find();
        for (int i = 0; i < m_cur; i++)
            if ((m_raw() & m_mask(i + 1)) != 0) return i;
        return -1;
    endfunction

    function automatic bit m_rd_ok(input logic [11:0] a);
        if (a[1:0] != 0) return 0;
        if ((a >= 12'h100 && a < 12'h140) || (a >= 12'h200 && a < 12'h240) || a >= 12'hFE0) return 1;
        return a inside {12'h000, 12'h004, 12'h008, 12'h00C, 12'h010, 12'h018, 12'h020, 12'h030, 12'h034};
    endfunction

    function automatic bit m_wr_ok(input logic [11:0] a);
        if (a[1:0] != 0) return 0;
        if ((a >= 12'h100 && a < 12'h140) || (a >= 12'h200 && a < 12'h240)) return 1;
        return a inside {12'h000, 12'h00C, 12'h010, 12'h014, 12'h018, 12'h01C, 12'h020, 12'h030, 12'h034};
    endfunction

    function automatic logic [31:0] m_read(input logic [11:0] a);
        int i;
        logic [7:0] ids [8] = '{8'h90, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        if (!m_rd_ok(a)) return '0;
        if (a >= 12'h100 && a < 12'h140) return m_vaddr[(a - 12'h100) >> 2];
        if (a >= 12'h200 && a < 12'h240) return {24'h0, m_ctl[(a - 12'h200) >> 2]};
        if (a >= 12'hFE0) return {24'h0, ids[(a - 12'hFE0) >> 2]};
        case (a)
            12'h000: return m_raw() & m_en & ~m_fsel;
            12'h004: return m_raw() & m_fsel;
            12'h008: return m_raw();
            12'h00C: return m_fsel;
            12'h010: return m_en;
            12'h018: return m_soft;
            12'h020: return {31'h0, m_prot};
            12'h030: begin
                i = m_find();
                if (i >= 0) return m_vaddr[i];
                return m_vaddr[(m_cur > 16) ? 16 : m_cur];
            end
            default: return m_vaddr[16];
        endcase
    endfunction

    task automatic m_apply(input bit w, input logic [11:0] a, input logic [31:0] d);
        int i;
        if (!w) begin
            if (a == 12'h030) begin
                i = m_find();
                if (i >= 0) begin m_prev[i] = m_cur; m_cur = i; end
            end
            return;
        end
        if (!m_wr_ok(a)) return;
        if (a >= 12'h100 && a < 12'h140) m_vaddr[(a - 12'h100) >> 2] = d;
        else if (a >= 12'h200 && a < 12'h240) m_ctl[(a - 12'h200) >> 2] = d[7:0];
        else case (a)
            12'h00C: m_fsel = d;
            12'h010: m_en = m_en | d;
            12'h014: m_en = m_en & ~d;
            12'h018: m_soft = m_soft | d;
            12'h01C: m_soft = m_soft & ~d;
            12'h020: m_prot = d[0];
            12'h030: if (m_cur < 17) m_cur = m_prev[m_cur];
            12'h034: m_vaddr[16] = d;
            default: ;
        endcase
    endtask

    task automatic m_reset();
        m_hw = '0; m_soft = '0; m_en = '0; m_fsel = '0; m_prot = 1'b0;
        m_cur = 17;
        for (int i = 0; i < 17; i++) begin m_vaddr[i] = '0; m_prev[i] = 17; end
        for (int i = 0; i < 16; i++) m_ctl[i] = '0;
    endtask

    // one clock: drive, compare against the model, then advance the model
    task automatic step(input bit v, input bit w, input logic [11:0] a,
                        input logic [31:0] d, input string tag);
        @(negedge clk);
        req_valid = v; req_write = w; req_addr = a; req_wdata = d; irq_in = m_hw;
        #1;
        chk("R4 irq_out", {31'h0, irq_out}, {31'h0, ((m_raw() & m_en & ~m_fsel & m_mask(m_cur)) != 0)});
        chk("R5 fiq_out", {31'h0, fiq_out}, {31'h0, ((m_raw() & m_fsel) != 0)});
        chk("R11 rsp_err", {31'h0, rsp_err}, {31'h0, v && (w ? !m_wr_ok(a) : !m_rd_ok(a))});
        if (v && !w) chk(tag, rsp_rdata, m_read(a));
        if (v) m_apply(w, a, d);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        step(1, 1, a, d, "wr");
    endtask
    task automatic rd(input logic [11:0] a, input string tag);
        step(1, 0, a, '0, tag);
    endtask
    task automatic idle();
        step(0, 0, '0, '0, "idle");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        m_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset state
        idle();
        rd(12'h100, "R1 vaddr0"); rd(12'h13C, "R1 vaddr15"); rd(12'h200, "R1 ctl0");
        rd(12'h23C, "R1 ctl15"); rd(12'h034, "R1 default"); rd(12'h010, "R1 enable");
        rd(12'h020, "R1 prot"); rd(12'h030, "R1 R8 idle vector");

        // R3 set/clear ports
        wr(12'h010, 32'h0000_00FF); wr(12'h014, 32'h0000_0003);
        rd(12'h010, "R3 enable");
        wr(12'h018, 32'h0000_1010); wr(12'h01C, 32'h0000_1000);
        rd(12'h018, "R3 soft");
        wr(12'h020, 32'hFFFF_FFFF); rd(12'h020, "R3 prot");
        wr(12'h014, 32'hFFFF_FFFF); wr(12'h01C, 32'hFFFF_FFFF);

        // R2 / R5 status composition, fast line ignores enable
        m_hw = 32'h8000_0024; idle();
        rd(12'h008, "R2 raw"); rd(12'h000, "R2 irq status");
        wr(12'h00C, 32'h0000_0004);
        rd(12'h004, "R2 fiq status"); rd(12'h00C, "R3 fsel");
        wr(12'h010, 32'h8000_0000); rd(12'h000, "R2 irq status en");
        wr(12'h00C, 32'h0); wr(12'h014, 32'hFFFF_FFFF);
        m_hw = '0; idle();

        // program slots (R12: gating follows on next clock)
        wr(12'h034, 32'h0000_DEAD);
        wr(12'h100, 32'h0000_1000); wr(12'h200, 32'h25);  // slot0 -> src5
        wr(12'h104, 32'h0000_2000); wr(12'h204, 32'h27);  // slot1 -> src7
        wr(12'h108, 32'h0000_3000); wr(12'h208, 32'h0B);  // slot2 bound, disabled
        rd(12'h204, "R12 ctl1"); rd(12'h104, "R12 vaddr1");
        wr(12'h010, 32'h0000_0AA0);

        // R6 acknowledge, R7 nesting and unwinding
        m_hw = 32'h0000_0280; idle();                      // src7, src9
        rd(12'h030, "R6 ack slot1");
        idle();
        m_hw = 32'h0000_02A0; idle();                      // src5 joins
        rd(12'h030, "R7 nested ack slot0");
        rd(12'h030, "R8 no qualifying level");
        wr(12'h030, 32'hFFFF_FFFF); idle();                // back to level 1
        rd(12'h000, "R7 status in service");
        wr(12'h030, 32'h0); idle();                        // back to idle
        m_hw = 32'h0000_0200; idle();                      // unvectored src9
        rd(12'h030, "R6 default level");
        wr(12'h030, 32'h0); idle();
        wr(12'h030, 32'h0); idle();                        // R9 idle pop has no effect
        rd(12'h030, "R9 after idle pop");
        wr(12'h030, 32'h0);

        // R12 rebinding slot0 to src9 changes masking next clock
        wr(12'h200, 32'h29); idle();
        rd(12'h030, "R12 rebind ack");
        wr(12'h030, 32'h0);
        m_hw = '0; idle();
        rd(12'h030, "R8 idle default");

        // R10 identification words
        for (int k = 0; k < 8; k++) rd(12'hFE0 + 12'(4 * k), "R10 id");

        // R11 unmapped / ignored accesses
        wr(12'h000, 32'hFFFF_FFFF); rd(12'h000, "R11 write to 0 ignored");
        rd(12'h040, "R11 unmapped read");
        rd(12'h014, "R11 clear-only read");
        wr(12'h300, 32'h1); wr(12'h008, 32'hFFFF_FFFF); wr(12'h102, 32'h5);
        rd(12'h100, "R11 misaligned write ignored");
        rd(12'h008, "R11 raw unchanged");
        idle(); idle();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule